// File: doc/BRIEF.md
# Strobe-Timed Slave FIFO Write Master

This block sits in an external device and pushes bytes into a slave FIFO whose write port is timed by strobe edges rather than by a shared clock. The user side hands over bytes one at a time through a valid/ready handshake. Each byte carries a last-byte marker and a commit request. The pin side drives a FIFO buffer address, an active-low chip select, an active-low write strobe, an active-low packet-end strobe and the data bus. It also watches a full flag from the FIFO.

Every interval that the FIFO asks for is a run-time cycle count. These intervals are address setup and hold, data setup and hold, the strobe low and high widths, the packet-end low and high widths, and the settle time before the full flag is trusted. A count of zero is treated as one cycle. The controller steps through a fixed order of phases: address setup, strobe low, strobe high, either a further byte or a packet-end pulse, and then address hold. As a result the packet-end strobe and the write strobe can never be low at the same time, and the address lines stay frozen for the whole transaction.

Top module: `sfifo_wr_master`

## Requirements
- R1: While reset is held and right after it, cs_n, wr_n and pktend_n are high and s_ready is high.
- R2: fifo_addr takes buf_addr when the first byte of a packet is accepted. It stays constant from the cycle cs_n goes low until cs_n returns high. At every write strobe it equals that packet's buf_addr.
- R3: cs_n goes low in the cycle after the first byte is accepted. The first wr_n low follows exactly max(1,cfg_addr_setup) cycles of cs_n low, or later only while flag_full is high.
- R4: Each wr_n low pulse lasts exactly max(1,cfg_wr_low,cfg_data_setup) cycles. During the pulse, data_out holds the accepted byte, in acceptance order.
- R5: Between two write pulses, wr_n stays high for at least max(1,cfg_wr_high,cfg_data_hold,cfg_flag_settle) cycles. The next byte is accepted only at the end of that interval.
- R6: No write pulse begins while flag_full is high at the end of address setup or strobe high. The transfer waits with wr_n high and resumes once the flag clears.
- R7: If the last byte was accepted with s_commit high, pktend_n goes low once for exactly max(1,cfg_pe_low) cycles. It starts only after at least the strobe-high interval of R5, and it is never low while wr_n is low.
- R8: cs_n returns high after max(1,cfg_pe_high)+max(1,cfg_addr_hold) cycles from the pktend_n rise. Without a commit, it returns high after max(1,cfg_addr_hold) cycles from the end of the final strobe-high interval.
- R9: s_ready is high only when idle or at the end of a strobe-high interval with flag_full low. It is never high while wr_n or pktend_n is low.
- R10: A packet produces one write pulse per accepted byte and at most one packet-end pulse. One byte and then a back-to-back burst of three bytes with commit give four write pulses and one packet-end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_setup | input | CNT_W | Cycles of address before the first strobe |
| cfg_addr_hold | input | CNT_W | Cycles of address after the final pulse |
| cfg_data_setup | input | CNT_W | Cycles of data before the strobe rises |
| cfg_data_hold | input | CNT_W | Cycles of data after the strobe rises |
| cfg_wr_low | input | CNT_W | Minimum write strobe low width |
| cfg_wr_high | input | CNT_W | Minimum write strobe high width |
| cfg_pe_low | input | CNT_W | Packet-end low width |
| cfg_pe_high | input | CNT_W | Packet-end high width before hold |
| cfg_flag_settle | input | CNT_W | Cycles after strobe rise before the full flag is sampled |
| buf_addr | input | ADDR_W | Target buffer, taken with the first byte |
| s_valid | input | 1 | Byte offered |
| s_data | input | DATA_W | Byte value |
| s_last | input | 1 | Byte closes the packet |
| s_commit | input | 1 | With s_last: commit as short packet |
| s_ready | output | 1 | Byte taken on this edge if s_valid |
| flag_full | input | 1 | FIFO full, active high |
| fifo_addr | output | ADDR_W | FIFO buffer address pins |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| pktend_n | output | 1 | Packet-end strobe, active low |
| data_out | output | DATA_W | Data bus |

## Verification
All pin outputs decode the phase register directly, so each pin changes in the cycle after the edge that moved the phase. cs_n falls one cycle after the edge that accepts a byte. wr_n falls after the setup count has run and rises after the low count. pktend_n and the final cs_n rise follow the same rule, with their own counts. A monitor samples on the falling clock edge and counts consecutive samples of each pin level. It compares each run with the clamped maxima above: exactly where flag_full never intervened, and as a lower bound where it did. Bytes are scored against the order in which the driver saw them accepted.

// File: rtl/sfw_pkg.sv
`timescale 1ns/1ps
package sfw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ADDR_SETUP = 3'd1,
    ST_STB_LOW    = 3'd2,
    ST_STB_HIGH   = 3'd3,
    ST_PE_LOW     = 3'd4,
    ST_PE_HIGH    = 3'd5,
    ST_ADDR_HOLD  = 3'd6
  } sfw_state_e;
endpackage

// File: rtl/sfw_phase_timer.sv
`timescale 1ns/1ps
module sfw_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (load)            remain <= load_len - CNT_W'(1);
    else if (remain != '0)    remain <= remain - CNT_W'(1);
  end

  assign done = (remain == '0);

  // R4: a phase is never loaded with a zero length
  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len != '0));
endmodule

// File: rtl/sfw_beat_hold.sv
`timescale 1ns/1ps
module sfw_beat_hold #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_byte,
  input  logic              take_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_commit,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [DATA_W-1:0] data_q,
  output logic              last_q,
  output logic              commit_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      last_q   <= 1'b0;
      commit_q <= 1'b0;
    end else if (take_byte) begin
      data_q   <= in_data;
      last_q   <= in_last;
      commit_q <= in_last & in_commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (take_addr) addr_q <= in_addr;
  end
endmodule

// File: rtl/sfw_seq.sv
`timescale 1ns/1ps
module sfw_seq
  import sfw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             flag_full,
  input  logic             last_q,
  input  logic             commit_q,
  input  logic             tmr_done,
  input  logic [CNT_W-1:0] cfg_addr_setup,
  input  logic [CNT_W-1:0] cfg_addr_hold,
  input  logic [CNT_W-1:0] cfg_data_setup,
  input  logic [CNT_W-1:0] cfg_data_hold,
  input  logic [CNT_W-1:0] cfg_wr_low,
  input  logic [CNT_W-1:0] cfg_wr_high,
  input  logic [CNT_W-1:0] cfg_pe_low,
  input  logic [CNT_W-1:0] cfg_pe_high,
  input  logic [CNT_W-1:0] cfg_flag_settle,
  output sfw_state_e       state,
  output logic             s_ready,
  output logic             take_byte,
  output logic             take_addr,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len
);
  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CNT_W-1:0] len_setup, len_low, len_high, len_pel, len_peh, len_hold;
  assign len_setup = floor_one(cfg_addr_setup);
  assign len_low   = floor_one(larger(cfg_wr_low, cfg_data_setup));
  assign len_high  = floor_one(larger(larger(cfg_wr_high, cfg_data_hold), cfg_flag_settle));
  assign len_pel   = floor_one(cfg_pe_low);
  assign len_peh   = floor_one(cfg_pe_high);
  assign len_hold  = floor_one(cfg_addr_hold);

  sfw_state_e state_d;
  logic       gate_open;
  assign gate_open = tmr_done & ~flag_full;

  always_comb begin
    state_d   = state;
    s_ready   = 1'b0;
    take_byte = 1'b0;
    take_addr = 1'b0;
    tmr_load  = 1'b0;
    tmr_len   = len_setup;
    unique case (state)
      ST_IDLE: begin
        s_ready = 1'b1;
        if (s_valid) begin
          take_byte = 1'b1;
          take_addr = 1'b1;
          tmr_load  = 1'b1;
          tmr_len   = len_setup;
          state_d   = ST_ADDR_SETUP;
        end
      end
      ST_ADDR_SETUP: begin
        if (gate_open) begin
          tmr_load = 1'b1;
          tmr_len  = len_low;
          state_d  = ST_STB_LOW;
        end
      end
      ST_STB_LOW: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_len  = len_high;
          state_d  = ST_STB_HIGH;
        end
      end
      ST_STB_HIGH: begin
        if (gate_open) begin
          if (!last_q) begin
            s_ready = 1'b1;
            if (s_valid) begin
              take_byte = 1'b1;
              tmr_load  = 1'b1;
              tmr_len   = len_low;
              state_d   = ST_STB_LOW;
            end
          end else if (commit_q) begin
            tmr_load = 1'b1;
            tmr_len  = len_pel;
            state_d  = ST_PE_LOW;
          end else begin
            tmr_load = 1'b1;
            tmr_len  = len_hold;
            state_d  = ST_ADDR_HOLD;
          end
        end
      end
      ST_PE_LOW: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_len  = len_peh;
          state_d  = ST_PE_HIGH;
        end
      end
      ST_PE_HIGH: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_len  = len_hold;
          state_d  = ST_ADDR_HOLD;
        end
      end
      ST_ADDR_HOLD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R6: full seen at a decision point never lets a strobe start next cycle
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ADDR_SETUP || state == ST_STB_HIGH) && flag_full) |=> (state != ST_STB_LOW));

  // R9: ready only when idle or when the strobe-high interval has run out
  p_ready_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (state == ST_IDLE) || (state == ST_STB_HIGH && tmr_done && !flag_full));

  // R7: packet-end phase is only ever reached from strobe high
  p_pe_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PE_LOW && $past(state) != ST_PE_LOW) |-> ($past(state) == ST_STB_HIGH));
endmodule

// File: rtl/sfifo_wr_master.sv
`timescale 1ns/1ps
module sfifo_wr_master
  import sfw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_addr_setup,
  input  logic [CNT_W-1:0]  cfg_addr_hold,
  input  logic [CNT_W-1:0]  cfg_data_setup,
  input  logic [CNT_W-1:0]  cfg_data_hold,
  input  logic [CNT_W-1:0]  cfg_wr_low,
  input  logic [CNT_W-1:0]  cfg_wr_high,
  input  logic [CNT_W-1:0]  cfg_pe_low,
  input  logic [CNT_W-1:0]  cfg_pe_high,
  input  logic [CNT_W-1:0]  cfg_flag_settle,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_commit,
  output logic              s_ready,
  input  logic              flag_full,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic              cs_n,
  output logic              wr_n,
  output logic              pktend_n,
  output logic [DATA_W-1:0] data_out
);
  localparam int RUN_W = CNT_W + 1;

  sfw_state_e       state;
  logic             take_byte, take_addr, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  logic             last_q, commit_q;

  sfw_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .flag_full(flag_full),
    .last_q(last_q), .commit_q(commit_q), .tmr_done(tmr_done),
    .cfg_addr_setup(cfg_addr_setup), .cfg_addr_hold(cfg_addr_hold),
    .cfg_data_setup(cfg_data_setup), .cfg_data_hold(cfg_data_hold),
    .cfg_wr_low(cfg_wr_low), .cfg_wr_high(cfg_wr_high),
    .cfg_pe_low(cfg_pe_low), .cfg_pe_high(cfg_pe_high),
    .cfg_flag_settle(cfg_flag_settle),
    .state(state), .s_ready(s_ready), .take_byte(take_byte),
    .take_addr(take_addr), .tmr_load(tmr_load), .tmr_len(tmr_len)
  );

  sfw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_len(tmr_len), .done(tmr_done)
  );

  sfw_beat_hold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take_byte(take_byte), .take_addr(take_addr),
    .in_data(s_data), .in_last(s_last), .in_commit(s_commit), .in_addr(buf_addr),
    .data_q(data_out), .last_q(last_q), .commit_q(commit_q), .addr_q(fifo_addr)
  );

  assign cs_n     = (state == ST_IDLE);
  assign wr_n     = (state != ST_STB_LOW);
  assign pktend_n = (state != ST_PE_LOW);

  // Observation: run lengths of pin levels, for the width assertions
  logic [RUN_W-1:0] wr_low_run, wr_high_run, pe_low_run;
  logic             strobe_active, pe_active;
  assign strobe_active = ~wr_n;
  assign pe_active     = ~pktend_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_run  <= '0;
      wr_high_run <= '0;
      pe_low_run  <= '0;
    end else begin
      wr_low_run  <= strobe_active ? ((wr_low_run == '1) ? wr_low_run : wr_low_run + RUN_W'(1)) : '0;
      wr_high_run <= strobe_active ? '0 : ((wr_high_run == '1) ? wr_high_run : wr_high_run + RUN_W'(1));
      pe_low_run  <= pe_active ? ((pe_low_run == '1) ? pe_low_run : pe_low_run + RUN_W'(1)) : '0;
    end
  end

  p_pe_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_active && pe_active));

  p_cs_before_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(cs_n) == 1'b0));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(fifo_addr));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_active && $past(strobe_active)) |-> $stable(data_out));

  p_wr_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_low_run >= {1'b0, cfg_wr_low}) && (wr_low_run >= {1'b0, cfg_data_setup}));

  p_wr_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n) && !$past(cs_n) && ($past(state) == ST_STB_HIGH)) |->
      (wr_high_run >= {1'b0, cfg_wr_high}) && (wr_high_run >= {1'b0, cfg_data_hold}));

  p_pe_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pktend_n) |-> (pe_low_run >= {1'b0, cfg_pe_low}));

  p_pe_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pktend_n) |-> (wr_high_run >= {1'b0, cfg_wr_high}) && (wr_high_run >= {1'b0, cfg_flag_settle}));
endmodule

// File: tb/sfifo_wr_master_test.sv
`timescale 1ns/100ps
module sfifo_wr_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_addr_setup, cfg_addr_hold, cfg_data_setup, cfg_data_hold;
  logic [7:0] cfg_wr_low, cfg_wr_high, cfg_pe_low, cfg_pe_high, cfg_flag_settle;
  logic [1:0] buf_addr = '0;
  logic       s_valid = 0, s_last = 0, s_commit = 0, flag_full = 0;
  logic [7:0] s_data = '0;
  logic       s_ready, cs_n, wr_n, pktend_n;
  logic [1:0] fifo_addr;
  logic [7:0] data_out;

  always #2.5 clk = ~clk;

  sfifo_wr_master uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_setup(cfg_addr_setup), .cfg_addr_hold(cfg_addr_hold),
    .cfg_data_setup(cfg_data_setup), .cfg_data_hold(cfg_data_hold),
    .cfg_wr_low(cfg_wr_low), .cfg_wr_high(cfg_wr_high),
    .cfg_pe_low(cfg_pe_low), .cfg_pe_high(cfg_pe_high),
    .cfg_flag_settle(cfg_flag_settle),
    .buf_addr(buf_addr), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_commit(s_commit), .s_ready(s_ready), .flag_full(flag_full),
    .fifo_addr(fifo_addr), .cs_n(cs_n), .wr_n(wr_n), .pktend_n(pktend_n),
    .data_out(data_out)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at1(input int v);
    return (v < 1) ? 1 : v;
  endfunction
  function automatic int e_setup(); return at1(int'(cfg_addr_setup)); endfunction
  function automatic int e_low();
    int m = int'(cfg_wr_low);
    if (int'(cfg_data_setup) > m) m = int'(cfg_data_setup);
    return at1(m);
  endfunction
  function automatic int e_high();
    int m = int'(cfg_flag_settle);
    if (int'(cfg_wr_high) > m) m = int'(cfg_wr_high);
    if (int'(cfg_data_hold) > m) m = int'(cfg_data_hold);
    return at1(m);
  endfunction
  function automatic int e_pel();  return at1(int'(cfg_pe_low));    endfunction
  function automatic int e_peh();  return at1(int'(cfg_pe_high));   endfunction
  function automatic int e_hold(); return at1(int'(cfg_addr_hold)); endfunction

  // Scoreboard filled by the driver at each accepting edge
  logic [7:0] exp_q [0:2047];
  int  wp = 0, rp = 0;
  int  pkt_bytes = 0;
  bit  exp_commit = 0;
  logic [1:0] exp_addr = '0;
  int  strobe_total = 0, pe_total = 0, pkt_done = 0;

  // Monitor: samples on the falling edge
  bit p_wr = 1, p_cs = 1, p_pe = 1;
  logic [1:0] p_addr = '0;
  int since_cs = 0, low_run = 0, high_run = 0, pe_run = 0, tail = 0;
  int strobes = 0, pes = 0;
  bit first = 0, saw_full = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_wr = 1; p_cs = 1; p_pe = 1;
    end else begin
      // R9
      if (s_ready && !cs_n)
        chk(wr_n && pktend_n && !flag_full, "R9 ready outside window", 1, 0);
      if (!cs_n && !p_cs)
        chk(fifo_addr == p_addr, "R2 address moved under cs", int'(fifo_addr), int'(p_addr));
      if (p_cs && !cs_n) begin
        since_cs = 0; strobes = 0; pes = 0; first = 1; saw_full = 0; tail = 0;
      end
      if (!cs_n && flag_full) saw_full = 1;
      if (!pktend_n)
        chk(wr_n == 1'b1, "R7 pktend overlaps wr", 0, 1);
      // write strobe edges
      if (p_wr && !wr_n) begin
        strobes++; strobe_total++;
        if (first) begin
          if (saw_full) chk(since_cs >= e_setup(), "R3 setup too short", since_cs, e_setup());
          else          chk(since_cs == e_setup(), "R3 setup length", since_cs, e_setup());
          first = 0;
        end else begin
          chk(high_run >= e_high(), "R5 high width", high_run, e_high());
        end
        low_run = 1;
      end else if (!wr_n) begin
        low_run++;
      end else if (!p_wr && wr_n) begin
        chk(low_run == e_low(), "R4 low width", low_run, e_low());
        chk(data_out == exp_q[rp], "R4 data order", int'(data_out), int'(exp_q[rp]));
        rp++;
        chk(fifo_addr == exp_addr, "R2 address at strobe", int'(fifo_addr), int'(exp_addr));
        high_run = 1;
      end else if (!cs_n) begin
        high_run++;
      end
      // packet-end edges
      if (p_pe && !pktend_n) begin
        chk(high_run >= e_high(), "R7 pktend too early", high_run, e_high());
        pe_run = 1; pes++; pe_total++;
      end else if (!pktend_n) begin
        pe_run++;
      end else if (!p_pe && pktend_n) begin
        chk(pe_run == e_pel(), "R7 pktend width", pe_run, e_pel());
        tail = 1;
      end else if (!cs_n && tail > 0) begin
        tail++;
      end
      // end of transaction
      if (!p_cs && cs_n) begin
        if (exp_commit)
          chk(tail == e_peh() + e_hold(), "R8 tail after pktend", tail, e_peh() + e_hold());
        else if (!saw_full)
          chk(high_run == e_high() + e_hold(), "R8 tail after strobe", high_run, e_high() + e_hold());
        else
          chk(high_run >= e_high() + e_hold(), "R8 tail after strobe", high_run, e_high() + e_hold());
        chk(strobes == pkt_bytes, "R10 strobes per packet", strobes, pkt_bytes);
        chk(pes == (exp_commit ? 1 : 0), "R10 pktend count", pes, exp_commit ? 1 : 0);
        pkt_done++;
      end
      if (!cs_n) since_cs++;
      p_wr = wr_n; p_cs = cs_n; p_pe = pktend_n; p_addr = fifo_addr;
    end
  end

  // Random full flag, changed half a ns after the rising edge
  bit rand_full = 0;
  always begin
    @(posedge clk); #0.5;
    if (rand_full) flag_full = ($urandom_range(0, 5) == 0);
  end

  task automatic send_pkt(input int n, input logic [1:0] addr, input bit commit, input int gap_max);
    for (int i = 0; i < n; i++) begin
      s_data   = 8'($urandom);
      s_last   = (i == n - 1);
      s_commit = commit;
      buf_addr = addr;
      s_valid  = 1'b1;
      while (!s_ready) begin @(posedge clk); #1; end
      @(posedge clk);
      exp_q[wp] = s_data; wp++;
      if (i == 0) begin pkt_bytes = 1; exp_addr = addr; exp_commit = commit; end
      else pkt_bytes++;
      #1;
      s_valid = 1'b0;
      buf_addr = ~addr;
      if (gap_max > 0) repeat ($urandom_range(0, gap_max)) begin @(posedge clk); #1; end
    end
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (!cs_n) begin @(posedge clk); #1; end
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic set_cfg(input int su, input int ho, input int ds, input int dh, input int lo,
                         input int hi, input int pl, input int ph, input int st);
    cfg_addr_setup = 8'(su); cfg_addr_hold = 8'(ho); cfg_data_setup = 8'(ds);
    cfg_data_hold = 8'(dh); cfg_wr_low = 8'(lo); cfg_wr_high = 8'(hi);
    cfg_pe_low = 8'(pl); cfg_pe_high = 8'(ph); cfg_flag_settle = 8'(st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    void'($urandom(32'd4242));
    set_cfg(2, 2, 1, 1, 3, 2, 2, 1, 1);
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && pktend_n, "R1 pins in reset", {cs_n, wr_n, pktend_n}, 7);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && wr_n && pktend_n && s_ready, "R1 after reset",
        {cs_n, wr_n, pktend_n, s_ready}, 15);

    // R10: single byte then a burst of three, committed as a short packet
    n0 = pe_total;
    send_pkt(4, 2'd2, 1'b1, 0);
    wait_idle();
    chk(pe_total == n0 + 1, "R10 short packet commit", pe_total - n0, 1);
    chk(strobe_total == 4, "R10 four strobes", strobe_total, 4);

    // All-zero counts clamp to one cycle; no commit
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    send_pkt(3, 2'd1, 1'b0, 0);
    wait_idle();

    // Data setup dominates the low width, settle dominates the high width
    set_cfg(1, 3, 5, 1, 1, 1, 3, 2, 4);
    send_pkt(3, 2'd3, 1'b1, 2);
    wait_idle();

    // R6: full before the first strobe holds the transfer
    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1);
    flag_full = 1'b1;
    n0 = strobe_total;
    fork send_pkt(1, 2'd0, 1'b0, 0); join_none
    repeat (30) @(posedge clk);
    #1;
    chk(strobe_total == n0, "R6 no strobe while full", strobe_total - n0, 0);
    chk(!cs_n && wr_n, "R6 stall holds cs low, wr high", {cs_n, wr_n}, 1);
    flag_full = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(strobe_total == n0 + 1, "R6 resumes after full clears", strobe_total - n0, 1);
    wait_idle();

    // Random packets with random counts and random full flag
    rand_full = 1;
    for (int k = 0; k < 40; k++) begin
      set_cfg($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
              $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
              $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4));
      send_pkt($urandom_range(1, 6), 2'($urandom), 1'($urandom), 2);
      wait_idle();
    end
    rand_full = 0;
    flag_full = 0;
    wait_idle();
    chk(rp == wp, "R4 every byte written", rp, wp);
    chk(pkt_done == 44, "R10 packet count", pkt_done, 44);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule